// File: doc/BRIEF.md
# Two-Word Timebase and Interval Timer

This block keeps a wide system time count split across two 36-bit words. The low word uses only 35 bits and its top bit stays zero, so together the words hold a 71-bit count. An internal prescaler produces a tick strobe, at either a slow or a fast rate chosen by a mode pin. On every tick the block adds the programmed interval period to the count. It also reloads a time-to-go register from the period and raises a timer interrupt flag that stays up until the host clears it.

Two optional per-tick side functions sit beside the timebase. A quantum accumulator grows by a fixed step on each tick while it is enabled and no interrupt level is active. A sampling pointer, while its sign bit is set, makes each tick issue one store of the current program counter to the pointer's right-half address, and then steps both 18-bit halves of the pointer.

The store request leaves on a valid/ready channel. `st_valid` rises with the address and data and they hold steady until a cycle with `st_ready` high. If a request is still waiting when a tick arrives, that tick takes no sample and leaves the pointer alone. A new sample may launch in the same cycle that the previous one is accepted. The host reads and writes the timebase and the interval through plain strobe ports.

Top module: `dword_timebase`

## Requirements
- R1: While reset is asserted and just after it is released, the timebase words, period, time-to-go, interrupt flag, quantum and sampling pointer all read 0, and `st_valid` is 0.
- R2: A timebase write loads the high word and the low word, and bit 35 of the low word is forced to 0. A write in the same cycle as a tick takes priority, so the written values are the result.
- R3: The high-word read port shows the high word with bits 11:0 forced to 0. The low-word read port shows the low word unchanged.
- R4: A tick adds the period to the low word. Bits 36:35 of that sum are added into the high word, the high word wraps modulo 2^36, and the low word keeps bits 34:0. Without a tick or a write, both words hold their values.
- R5: An interval write loads the period and copies the same value into time-to-go, and the period can be read back. A tick reloads time-to-go from the period.
- R6: A tick occurs once every SLOW_DIV+1 cycles while `fast_mode`=0 and once every FAST_DIV+1 cycles while `fast_mode`=1. The mode is sampled when the prescaler reloads at a tick.
- R7: A tick sets `irq`. `irq` stays set until a cycle with `irq_clr`=1. If a tick and a clear come in the same cycle, `irq` ends up set.
- R8: A tick with `quant_en`=1 and `pi_active`=0 adds QUANT_STEP to `quant`, modulo 2^36. Any other tick leaves `quant` unchanged.
- R9: A tick with pointer bit 35 set, and no store waiting (`st_valid`=0 or `st_ready`=1), raises `st_valid` with `st_addr` = pointer bits 17:0 and `st_data` = `pc_in`. Both halves of the pointer (35:18 and 17:0) then increase by 1, each modulo 2^18. A waiting store holds its address and data until `st_ready`. A tick that finds a store waiting takes no sample and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 selects the fast tick rate, 0 selects the slow rate |
| tick | output | 1 | Tick strobe from the prescaler |
| tb_wr | input | 1 | Timebase write strobe |
| tb_wdata_hi | input | 36 | High word to write |
| tb_wdata_lo | input | 36 | Low word to write (bit 35 is ignored) |
| tb_rdata_hi | output | 36 | High word with its low 12 bits cleared |
| tb_rdata_lo | output | 36 | Low word |
| iv_wr | input | 1 | Interval write strobe |
| iv_wdata | input | 36 | Period to write |
| iv_rdata | output | 36 | Current period |
| ttg | output | 36 | Time-to-go register |
| irq_clr | input | 1 | Clears the timer interrupt flag |
| irq | output | 1 | Timer interrupt flag |
| quant_en | input | 1 | Enables the quantum accumulator |
| pi_active | input | 1 | An interrupt level is active |
| quant | output | 36 | Quantum accumulator |
| pc_in | input | 18 | Program counter to sample |
| samp_wr | input | 1 | Sampling pointer write strobe |
| samp_wdata | input | 36 | Sampling pointer value to write |
| samp_ptr | output | 36 | Sampling pointer |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | 18 | Store address |
| st_data | output | 18 | Store data (sampled program counter) |

## Verification
The timebase add is driven from a vector table with several contrasting cases. A plain add shows the low-word path by itself. A low word at its 35-bit maximum plus one shows the carry into the high word. An all-ones high word shows the 36-bit wrap. A low-word write with the sign bit set shows the forced clear. A zero period shows that a tick can leave the count unchanged while still reloading and flagging. The high-word read values are chosen to have nonzero low 12 bits, so a read that failed to mask them would show up. Directed cases cover the store channel with the consumer stalled and then ready, the tick-against-clear and tick-against-write collisions, and the tick spacing in both modes.

// File: rtl/dwtb_pkg.sv
package dwtb_pkg;
  localparam int WORD_W = 36;
  localparam int HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } dword_t;

  // add an increment to the two-word count; the low word keeps 35 bits
  function automatic dword_t dw_add(input dword_t b, input word_t inc);
    logic [WORD_W:0] sum;
    dword_t r;
    sum  = {1'b0, b.lo} + {1'b0, inc};
    r.lo = {1'b0, sum[WORD_W-2:0]};
    r.hi = b.hi + word_t'(sum[WORD_W:WORD_W-1]);
    return r;
  endfunction
endpackage

// File: rtl/dwtb_prescaler.sv
module dwtb_prescaler #(
  parameter int SLOW_DIV = 68332,
  parameter int FAST_DIV = 4094
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  output logic tick
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= CNT_W'(SLOW_DIV);
    else if (tick)       cnt <= fast_mode ? CNT_W'(FAST_DIV) : CNT_W'(SLOW_DIV);
    else                 cnt <= cnt - 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
endmodule

// File: rtl/dwtb_base.sv
module dwtb_base
  import dwtb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  word_t period,
  input  logic  wr,
  input  word_t wdata_hi,
  input  word_t wdata_lo,
  output word_t hi,
  output word_t lo
);
  dword_t cur, nxt;

  assign nxt = dw_add(cur, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (wr) begin
      cur.hi <= wdata_hi;
      cur.lo <= {1'b0, wdata_lo[WORD_W-2:0]};
    end else if (tick) begin
      cur <= nxt;
    end
  end

  assign hi = cur.hi;
  assign lo = cur.lo;

  AST_LO_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !lo[WORD_W-1]); // R2
  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> ($stable(hi) && $stable(lo))); // R4
endmodule

// File: rtl/dwtb_sampler.sv
module dwtb_sampler
  import dwtb_pkg::*;
#(
  parameter int QUANT_STEP = 68333
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  quant_en,
  input  logic  pi_active,
  input  half_t pc_in,
  input  logic  samp_wr,
  input  word_t samp_wdata,
  input  logic  st_ready,
  output word_t quant,
  output word_t samp_ptr,
  output logic  st_valid,
  output half_t st_addr,
  output half_t st_data
);
  logic quant_go;
  logic take;
  half_t ptr_l, ptr_r;

  assign quant_go = tick && quant_en && !pi_active;
  assign take     = tick && samp_ptr[WORD_W-1] && (!st_valid || st_ready);
  assign ptr_l    = samp_ptr[WORD_W-1:HALF_W];
  assign ptr_r    = samp_ptr[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)        quant <= '0;
    else if (quant_go) quant <= quant + word_t'(QUANT_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       samp_ptr <= '0;
    else if (samp_wr) samp_ptr <= samp_wdata;
    else if (take)    samp_ptr <= {ptr_l + 1'b1, ptr_r + 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
    end else if (take) begin
      st_valid <= 1'b1;
      st_addr  <= ptr_r;
      st_data  <= pc_in;
    end else if (st_ready) begin
      st_valid <= 1'b0;
    end
  end

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data))); // R9
  AST_QUANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && quant_en && !pi_active) |=> $stable(quant)); // R8
endmodule

// File: rtl/dword_timebase.sv
module dword_timebase
  import dwtb_pkg::*;
#(
  parameter int SLOW_DIV   = 4100000 / 60 - 1,
  parameter int FAST_DIV   = 4100000 / 1001 - 1,
  parameter int QUANT_STEP = 4100000 / 60,
  parameter int MASK_LSBS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fast_mode,
  output logic                 tick,
  input  logic                 tb_wr,
  input  logic [WORD_W-1:0]    tb_wdata_hi,
  input  logic [WORD_W-1:0]    tb_wdata_lo,
  output logic [WORD_W-1:0]    tb_rdata_hi,
  output logic [WORD_W-1:0]    tb_rdata_lo,
  input  logic                 iv_wr,
  input  logic [WORD_W-1:0]    iv_wdata,
  output logic [WORD_W-1:0]    iv_rdata,
  output logic [WORD_W-1:0]    ttg,
  input  logic                 irq_clr,
  output logic                 irq,
  input  logic                 quant_en,
  input  logic                 pi_active,
  output logic [WORD_W-1:0]    quant,
  input  logic [HALF_W-1:0]    pc_in,
  input  logic                 samp_wr,
  input  logic [WORD_W-1:0]    samp_wdata,
  output logic [WORD_W-1:0]    samp_ptr,
  output logic                 st_valid,
  input  logic                 st_ready,
  output logic [HALF_W-1:0]    st_addr,
  output logic [HALF_W-1:0]    st_data
);
  localparam word_t RD_MASK = ~((word_t'(1) << MASK_LSBS) - word_t'(1));

  word_t period;
  word_t tb_hi, tb_lo;

  dwtb_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .tick(tick)
  );

  dwtb_base u_base (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .wr(tb_wr), .wdata_hi(tb_wdata_hi), .wdata_lo(tb_wdata_lo),
    .hi(tb_hi), .lo(tb_lo)
  );

  dwtb_sampler #(.QUANT_STEP(QUANT_STEP)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .quant_en(quant_en), .pi_active(pi_active), .pc_in(pc_in),
    .samp_wr(samp_wr), .samp_wdata(samp_wdata), .st_ready(st_ready),
    .quant(quant), .samp_ptr(samp_ptr),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      ttg    <= '0;
    end else if (iv_wr) begin
      period <= iv_wdata;
      ttg    <= iv_wdata;
    end else if (tick) begin
      ttg    <= period;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (tick)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign iv_rdata    = period;
  assign tb_rdata_hi = tb_hi & RD_MASK;
  assign tb_rdata_lo = tb_lo;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tick) |=> !irq); // R7
  AST_TTG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick || iv_wr) |=> (ttg == iv_rdata)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R7
endmodule

// File: tb/sim_dword_timebase.sv
module sim_dword_timebase;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SDIV = 9;
  localparam int FDIV = 3;
  localparam logic [35:0] QSTEP = 36'd68333;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_mode = 1'b0;
  logic tick;
  logic tb_wr = 1'b0;
  logic [35:0] tb_wdata_hi = '0, tb_wdata_lo = '0;
  logic [35:0] tb_rdata_hi, tb_rdata_lo;
  logic iv_wr = 1'b0;
  logic [35:0] iv_wdata = '0;
  logic [35:0] iv_rdata, ttg;
  logic irq_clr = 1'b0;
  logic irq;
  logic quant_en = 1'b0, pi_active = 1'b0;
  logic [35:0] quant;
  logic [17:0] pc_in = '0;
  logic samp_wr = 1'b0;
  logic [35:0] samp_wdata = '0;
  logic [35:0] samp_ptr;
  logic st_valid;
  logic st_ready = 1'b0;
  logic [17:0] st_addr, st_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dword_timebase #(.SLOW_DIV(SDIV), .FAST_DIV(FDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .tick(tick),
    .tb_wr(tb_wr), .tb_wdata_hi(tb_wdata_hi), .tb_wdata_lo(tb_wdata_lo),
    .tb_rdata_hi(tb_rdata_hi), .tb_rdata_lo(tb_rdata_lo),
    .iv_wr(iv_wr), .iv_wdata(iv_wdata), .iv_rdata(iv_rdata), .ttg(ttg),
    .irq_clr(irq_clr), .irq(irq), .quant_en(quant_en), .pi_active(pi_active),
    .quant(quant), .pc_in(pc_in), .samp_wr(samp_wr), .samp_wdata(samp_wdata),
    .samp_ptr(samp_ptr), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data)
  );

  // vector: write hi, write lo, period, expected hi read, expected lo read (after one tick)
  localparam logic [179:0] VEC [0:4] = '{
    {36'h000000000, 36'h000000000, 36'h000000005, 36'h000000000, 36'h000000005},
    {36'h000001234, 36'h7FFFFFFFF, 36'h000000001, 36'h000001000, 36'h000000000},
    {36'hFFFFFFFFF, 36'h7FFFFFFF0, 36'h000000020, 36'h000000000, 36'h000000010},
    {36'h000000ABC, 36'h800000003, 36'h000000010, 36'h000000000, 36'h000000013},
    {36'h123456789, 36'h0000000AA, 36'h000000000, 36'h123456000, 36'h0000000AA}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] q0;
    int gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {35'd0, irq}, 36'd0);
    chk("R1 period", iv_rdata, 36'd0);
    chk("R1 ttg", ttg, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tb hi", tb_rdata_hi, 36'd0);
    chk("R1 tb lo", tb_rdata_lo, 36'd0);
    chk("R1 quant", quant, 36'd0);
    chk("R1 ptr", samp_ptr, 36'd0);
    chk("R1 st_valid", {35'd0, st_valid}, 36'd0);

    // R7 interrupt set, hold, clear, tick beats clear
    wait_tick();
    @(negedge clk);
    chk("R7 set", {35'd0, irq}, 36'd1);
    repeat (4) @(negedge clk);
    chk("R7 hold", {35'd0, irq}, 36'd1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R7 clear", {35'd0, irq}, 36'd0);
    wait_tick();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R7 tick wins", {35'd0, irq}, 36'd1);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 5; i++) begin
      logic [35:0] whi, wlo, per, ehi, elo;
      {whi, wlo, per, ehi, elo} = VEC[i];
      wait_tick();
      @(negedge clk);
      tb_wr = 1'b1; tb_wdata_hi = whi; tb_wdata_lo = wlo;
      iv_wr = 1'b1; iv_wdata = per;
      @(negedge clk);
      tb_wr = 1'b0; iv_wr = 1'b0;
      chk("R5 period", iv_rdata, per);
      chk("R5 ttg load", ttg, per);
      chk("R3 hi read", tb_rdata_hi, whi & ~36'hFFF);
      chk("R2 lo sign", tb_rdata_lo, {1'b0, wlo[34:0]});
      wait_tick();
      @(negedge clk);
      chk("R4 hi", tb_rdata_hi, ehi);
      chk("R4 lo", tb_rdata_lo, elo);
      chk("R5 ttg reload", ttg, per);
    end

    // R2 write beats tick
    wait_tick();
    @(negedge clk);
    iv_wr = 1'b1; iv_wdata = 36'd7;
    @(negedge clk);
    iv_wr = 1'b0;
    wait_tick();
    tb_wr = 1'b1; tb_wdata_hi = 36'h5000; tb_wdata_lo = 36'h42;
    @(negedge clk);
    tb_wr = 1'b0;
    chk("R2 write wins lo", tb_rdata_lo, 36'h42);
    chk("R2 write wins hi", tb_rdata_hi, 36'h5000);

    // R6 cadence slow then fast
    wait_tick();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick);
    chk("R6 slow gap", 36'(gap), 36'(SDIV + 1));
    fast_mode = 1'b1;
    wait_tick();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick);
    chk("R6 fast gap", 36'(gap), 36'(FDIV + 1));
    fast_mode = 1'b0;
    wait_tick();

    // R8 quantum
    @(negedge clk);
    quant_en = 1'b1;
    q0 = quant;
    wait_tick();
    @(negedge clk);
    chk("R8 add", quant, q0 + QSTEP);
    pi_active = 1'b1;
    q0 = quant;
    wait_tick();
    @(negedge clk);
    chk("R8 pi active", quant, q0);
    pi_active = 1'b0; quant_en = 1'b0;
    q0 = quant;
    wait_tick();
    @(negedge clk);
    chk("R8 disabled", quant, q0);

    // R9 sampling and store channel
    samp_wr = 1'b1; samp_wdata = 36'hFFFFC0100; pc_in = 18'h2AAAA;
    @(negedge clk);
    samp_wr = 1'b0;
    chk("R9 ptr load", samp_ptr, 36'hFFFFC0100);
    wait_tick();
    @(negedge clk);
    chk("R9 valid", {35'd0, st_valid}, 36'd1);
    chk("R9 addr", {18'd0, st_addr}, 36'h100);
    chk("R9 data", {18'd0, st_data}, 36'h2AAAA);
    chk("R9 ptr step", samp_ptr, 36'h000000101);
    repeat (3) @(negedge clk);
    chk("R9 hold valid", {35'd0, st_valid}, 36'd1);
    chk("R9 hold addr", {18'd0, st_addr}, 36'h100);
    samp_wr = 1'b1; samp_wdata = 36'hFFFF80200; pc_in = 18'h11111;
    @(negedge clk);
    samp_wr = 1'b0;
    wait_tick();
    @(negedge clk);
    chk("R9 skip ptr", samp_ptr, 36'hFFFF80200);
    chk("R9 skip data", {18'd0, st_data}, 36'h2AAAA);
    st_ready = 1'b1;
    @(negedge clk);
    chk("R9 accepted", {35'd0, st_valid}, 36'd0);
    wait_tick();
    @(negedge clk);
    chk("R9 second valid", {35'd0, st_valid}, 36'd1);
    chk("R9 second addr", {18'd0, st_addr}, 36'h200);
    chk("R9 second data", {18'd0, st_data}, 36'h11111);
    chk("R9 second ptr", samp_ptr, 36'hFFFFC0201);
    @(negedge clk);
    chk("R9 drained", {35'd0, st_valid}, 36'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule